// File: doc/BRIEF.md
# Password-Armed Pin Write-Lock Unit

This unit guards the configuration of up to eight banks of 32 pins against stray writes. Each bank owns one 32-bit lock word in which each bit protects one pin: a 1 means the pin is locked and a 0 means it is free. The unit drives the lock words out as one flat vector. The neighbouring register logic uses that vector to drop writes to a locked pin's control register and to that pin's bits in the set and clear registers.

A lock word changes only through a two-step handshake on a simple register bus. First a magic value is written to a password register. The write to the lock word must come straight after it. Each correct password write allows exactly one lock update. Any other write in between cancels that permission. Reads leave the permission alone, so software can read a lock word, arm the unit and write the modified word back.

Top module: `pinlock_unit`

## Requirements
- R1: After reset, every bit of `lockVec` is 1, `armed` is 0 and `rdValid` is 0.
- R2: A write of 0x00A5A501 to byte address 0x520 (the password register) sets `armed` to 1 on the next cycle.
- R3: While `armed` is 1, a write to byte address 0x500 + 4*b (b below NUM_BANKS) loads the whole write word into bank b. Bit i of that word appears on `lockVec[32*b+i]` from the next cycle, and `armed` returns to 0.
- R4: A write to a lock address while `armed` is 0 leaves every lock word unchanged. This includes a second lock write after one arming has been used.
- R5: Any write that is not a correct password write clears `armed`: a wrong password value, or a write to any other address. A lock write that follows such a write is ignored.
- R6: A read (`rdEn` high for one cycle) raises `rdValid` on the next cycle with the addressed data on `rdata`. A lock address returns that bank's current lock word.
- R7: The password register reads as zero, and so does any address outside the lock words.
- R8: Reads do not change `armed`. The sequence read lock word, write password, read again, write lock word therefore updates the bank.
- R9: A lock update changes only the addressed bank. All other banks keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid when `rdValid` is high |
| rdValid | output | 1 | Read data valid, one cycle after `rdEn` |
| lockVec | output | NUM_BANKS*32 | Per-pin lock bits, bank b at bits 32*b+31 down to 32*b |
| armed | output | 1 | Test status: a password write is pending use |

## Verification
The checker watches several rules on every cycle:
- the lock vector never changes unless an armed write happened the cycle before;
- `armed` rises only after a correct password write;
- every other write drops `armed`;
- each read produces a valid response one cycle later, with zero data for the password address.

Some behaviour can only be shown by the bench's scenarios:
- that the right bank receives the whole word while the other banks stay untouched;
- that a read between arming and the lock write keeps the update alive;
- that read-back returns the stored value.

// File: rtl/pinlock_pkg.sv
package pinlock_pkg;
  localparam int MAX_BANKS  = 8;
  localparam int PINS       = 32;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int BANK_IDX_W = $clog2(MAX_BANKS);
  localparam int REGION_LSB = BANK_IDX_W + 2;

  localparam logic [ADDR_W-1:0] PW_ADDR   = 12'h520;
  localparam logic [ADDR_W-1:0] LOCK_BASE = 12'h500;
  localparam logic [DATA_W-1:0] PW_VALUE  = 32'h00A5A501;

  typedef struct packed {
    logic [MAX_BANKS-1:0]  load;
    logic [DATA_W-1:0]     word;
    logic                  rdGo;
    logic                  rdLock;
    logic [BANK_IDX_W-1:0] rdBank;
  } strobe_t;
endpackage

// File: rtl/pinlock_ctrl.sv
module pinlock_ctrl
  import pinlock_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           strobes,
  output logic              armed
);
  logic                  pwHit;
  logic                  lockHit;
  logic                  pwGood;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  armedNext;

  always_comb begin
    pwHit   = (addr == PW_ADDR);
    lockHit = (addr[ADDR_W-1:REGION_LSB] == LOCK_BASE[ADDR_W-1:REGION_LSB]) &&
              (addr[1:0] == 2'b00);
    bankIdx = addr[REGION_LSB-1:2];
    pwGood  = pwHit && (wdata == PW_VALUE);
  end

  // Arming: set only by a good password write, cleared by any other write.
  always_comb begin
    armedNext = armed;
    if (wrEn) armedNext = pwGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= armedNext;
  end

  genvar b;
  generate
    for (b = 0; b < MAX_BANKS; b++) begin : g_load
      if (b < NUM_BANKS) begin : g_live
        assign strobes.load[b] = wrEn && armed && lockHit &&
                                 (bankIdx == BANK_IDX_W'(b));
      end else begin : g_absent
        assign strobes.load[b] = 1'b0;
      end
    end
  endgenerate

  assign strobes.word   = wdata;
  assign strobes.rdGo   = rdEn;
  assign strobes.rdLock = lockHit && (int'(bankIdx) < NUM_BANKS);
  assign strobes.rdBank = bankIdx;
endmodule

// File: rtl/pinlock_dp.sv
module pinlock_dp
  import pinlock_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobes,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rdValid,
  output logic [NUM_BANKS*PINS-1:0] lockVec
);
  logic [NUM_BANKS-1:0][PINS-1:0] lockWord;
  logic [DATA_W-1:0]              rdNext;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rstN)                lockWord[b] <= '1;
        else if (strobes.load[b]) lockWord[b] <= strobes.word;
      end
      assign lockVec[b*PINS +: PINS] = lockWord[b];
    end
  endgenerate

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (strobes.rdLock && (int'(strobes.rdBank) == i)) rdNext = lockWord[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata   <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdGo;
      if (strobes.rdGo) rdata <= rdNext;
    end
  end
endmodule

// File: rtl/pinlock_unit.sv
module pinlock_unit
  import pinlock_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [11:0]               addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic                      rdValid,
  output logic [NUM_BANKS*32-1:0]   lockVec,
  output logic                      armed
);
  strobe_t strobes;

  pinlock_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .strobes(strobes), .armed(armed)
  );

  pinlock_dp #(.NUM_BANKS(NUM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdata(rdata),
    .rdValid(rdValid), .lockVec(lockVec)
  );
endmodule

// File: rtl/pinlock_chk.sv
module pinlock_chk #(
  parameter int NUM_BANKS = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [11:0]             addr,
  input logic [31:0]             wdata,
  input logic [31:0]             rdata,
  input logic                    rdValid,
  input logic [NUM_BANKS*32-1:0] lockVec,
  input logic                    armed
);
  // R3 R4
  lock_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockVec) |-> $past(armed && wrEn));

  // R2
  arm_from_password_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(wrEn && addr == 12'h520 && wdata == 32'h00A5A501));

  // R5
  other_write_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !(addr == 12'h520 && wdata == 32'h00A5A501) |=> !armed);

  // R8
  read_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn && armed |=> armed);

  // R6
  read_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R7
  password_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && addr == 12'h520 |=> rdata == 32'h0);
endmodule

bind pinlock_unit pinlock_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rdValid(rdValid), .lockVec(lockVec),
  .armed(armed)
);

// File: tb/pinlock_unit_tb.sv
module pinlock_unit_tb;
  localparam int NB = 8;
  localparam logic [11:0] PWA = 12'h520;
  localparam logic [31:0] PWV = 32'h00A5A501;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rdValid;
  logic [NB*32-1:0] lockVec;
  logic          armed;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 0;
  logic [31:0] expLock [NB];
  logic [31:0] expQ [$];

  pinlock_unit #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdValid(rdValid), .lockVec(lockVec),
    .armed(armed)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data as responses appear (R6).
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) check("R6 unexpected rdValid", 1, 0);
      else check("R6 R7 readback", rdata, expQ.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1; addr = a; expQ.push_back(exp);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic chkAll(input string req);
    logic [NB*32-1:0] e;
    for (int b = 0; b < NB; b++) e[b*32 +: 32] = expLock[b];
    check(req, lockVec, e);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) expLock[b] = '1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 lockVec reset", lockVec, {NB*32{1'b1}});
    check("R1 armed reset", armed, 0);
    check("R1 rdValid reset", rdValid, 0);
    rstN = 1'b1;
    rd(12'h500, 32'hFFFF_FFFF);
    // R4: unarmed write ignored
    wr(12'h500, 32'h0);
    chkAll("R4 unarmed write");
    // R2 / R3
    wr(PWA, PWV);
    check("R2 armed after password", armed, 1);
    wr(12'h50C, 32'h0000_F00F);
    expLock[3] = 32'h0000_F00F;
    chkAll("R3 R9 bank3 load");
    check("R3 arm consumed", armed, 0);
    rd(12'h50C, 32'h0000_F00F);
    // R4: second write needs re-arming
    wr(12'h50C, 32'h0);
    chkAll("R4 second write ignored");
    // R5: wrong password
    wr(PWA, 32'h00A5_A500);
    check("R5 wrong password", armed, 0);
    wr(12'h50C, 32'h0);
    chkAll("R5 write after wrong password");
    // R5: intervening unrelated write
    wr(PWA, PWV);
    check("R2 re-arm", armed, 1);
    wr(12'h100, 32'h1234_5678);
    check("R5 other write disarms", armed, 0);
    wr(12'h50C, 32'h0);
    chkAll("R5 write after intervening write");
    // R7
    rd(PWA, 32'h0);
    rd(12'h104, 32'h0);
    // R8: read-modify-write with a read between arm and update
    rd(12'h51C, 32'hFFFF_FFFF);
    wr(PWA, PWV);
    rd(12'h51C, 32'hFFFF_FFFF);
    check("R8 read keeps arm", armed, 1);
    wr(12'h51C, 32'hFFFF_7FFF);
    expLock[7] = 32'hFFFF_7FFF;
    chkAll("R8 R3 RMW update bank7");
    // R3 R9: every bank with a distinct pattern
    for (int b = 0; b < NB; b++) begin
      wr(PWA, PWV);
      wr(12'h500 + 12'(4*b), 32'hA5C3_0000 ^ (32'h0101_0101 * b));
      expLock[b] = 32'hA5C3_0000 ^ (32'h0101_0101 * b);
      chkAll("R3 R9 per-bank load");
    end
    for (int b = 0; b < NB; b++) rd(12'h500 + 12'(4*b), expLock[b]);
    // R3: whole bank unlock then lock
    wr(PWA, PWV); wr(12'h504, 32'h0); expLock[1] = '0;
    chkAll("R3 unlock bank1");
    wr(PWA, PWV); wr(12'h504, '1); expLock[1] = '1;
    chkAll("R3 relock bank1");
    repeat (3) @(negedge clk);
    check("R6 all reads answered", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule